// File: doc/BRIEF.md
# Calendar Timekeeper with Alarm Compare

This block keeps wall-clock date and time in two packed words and advances them once per second. A prescaler counts enabled cycles of a 32768 Hz reference (presented as a one-cycle enable strobe, `osc_en`, in the system clock domain). Each time the prescaler wraps, the block issues a one-second tick. A small sequencer then steps the time of day, then the date, and finally compares the result against a stored alarm. The date word holds the full calendar year, the month and the day of the month. The time word holds week of month, day of week (1 to 7), hour, minute and second. Both derived fields are kept consistent as the counters roll over.

Software loads either counter word or either alarm word through a single write strobe with a 2-bit selector. Loading a counter word restarts the prescaler phase, so the first second after a write is a full second. An alarm hit is a single-cycle pulse. It fires when year, month, day, hour, minute and second all equal the alarm words. Day of week and week of month take no part in the compare.

Top module: `caltime_keeper`

## Requirements
- R1: After reset the date word reads year 2000, month 1, day 1, the time word reads week 1, weekday 1, 00:00:00, and `alarm_hit_o` and `sec_tick_o` are low.
- R2: `sec_tick_o` is high for one cycle once every DIV_RELOAD+1 cycles in which `osc_en` is high (default 32768); cycles with `osc_en` low do not advance the prescaler.
- R3: Seconds and minutes wrap from 59 to 0 and hours from 23 to 0, each carrying into the next field; the updated hour, minute and second are visible in the second cycle after the tick cycle.
- R4: On a day change the weekday steps 1..7 and wraps from 7 to 1, and the week of month becomes (day + 6) / 7 of the new day; these are visible in the third cycle after the tick cycle.
- R5: The day wraps to 1 after the last day of the month, with February having 29 days in years divisible by 4 except century years not divisible by 400; month 12 wraps to 1 and increments the year. The new date is visible in the third cycle after the tick cycle.
- R6: `alarm_hit_o` is high for exactly one cycle, the fourth cycle after a tick, when the stepped year, month, day, hour, minute and second all equal the alarm; weekday and week-of-month fields are not compared.
- R7: `wr_sel` selects 0 = date counter, 1 = time counter, 2 = alarm date, 3 = alarm time. A counter write loads the word on the next edge, restarts the prescaler so the next tick comes DIV_RELOAD+1 enabled cycles later, and abandons any step in progress. An alarm write changes neither the prescaler nor a step in progress.
- R8: Date word layout: year at bits 20:9, month at 8:5, day at 4:0. Time word layout: week of month at 22:20, weekday at 19:17, hour at 16:12, minute at 11:6, second at 5:0. A written word reads back unchanged in those fields.
- R9: Bits 31:21 of the date word and bits 31:23 of the time word are ignored on write and always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | One-cycle strobe per reference oscillator period |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Target word of a write (see R7) |
| wr_data | input | 32 | Write data in the packed layouts of R8 |
| date_o | output | 32 | Current date word |
| time_o | output | 32 | Current time word |
| sec_tick_o | output | 1 | One-second tick from the prescaler |
| alarm_hit_o | output | 1 | Single-cycle alarm match pulse |

## Verification
The hardest situation to reach from the ports is a counter write that lands in the few cycles between a tick and the end of its step sequence. Such a write must cancel the pending carry and leave only the written value. The bench polls `sec_tick_o` and issues the write on the very next cycle. A per-cycle reference model, which tracks the pending step as a small age counter, checks that the later stages never overwrite the loaded word. Month-end, leap-year, century and year-end rollovers are reached by loading the counters to 23:59:59 on the day before each boundary.

// File: rtl/caltime_pkg.sv
package caltime_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STEP_TIME,
        ST_STEP_DATE,
        ST_CHECK
    } step_state_e;

    // Field order of the packed structs fixes the bit positions of the words.
    typedef struct packed {
        logic [11:0] year;
        logic [3:0]  month;
        logic [4:0]  day;
    } date_t;

    typedef struct packed {
        logic [2:0] wom;
        logic [2:0] dow;
        logic [4:0] hour;
        logic [5:0] minute;
        logic [5:0] second;
    } tod_t;

    localparam date_t RST_DATE = '{year: 12'd2000, month: 4'd1, day: 5'd1};
    localparam tod_t  RST_TOD  = '{wom: 3'd1, dow: 3'd1, hour: 5'd0, minute: 6'd0, second: 6'd0};

    function automatic logic is_leap(input logic [11:0] yr);
        int y;
        y = int'(yr);
        return ((y % 4) == 0) && (((y % 100) != 0) || ((y % 400) == 0));
    endfunction

    function automatic logic [4:0] days_in_month(input logic [11:0] yr, input logic [3:0] mon);
        case (mon)
            4'd2:                    return is_leap(yr) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
            default:                 return 5'd31;
        endcase
    endfunction

    function automatic logic [2:0] week_of_month(input logic [4:0] day);
        if (day <= 5'd7)       return 3'd1;
        else if (day <= 5'd14) return 3'd2;
        else if (day <= 5'd21) return 3'd3;
        else if (day <= 5'd28) return 3'd4;
        else                   return 3'd5;
    endfunction

endpackage

// File: rtl/caltime_prescaler.sv
module caltime_prescaler #(
    parameter int unsigned DIV_RELOAD = 32767
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output logic tick
);
    localparam int unsigned CW = (DIV_RELOAD < 1) ? 1 : $clog2(DIV_RELOAD + 1);
    localparam logic [CW-1:0] LAST = CW'(DIV_RELOAD);

    logic [CW-1:0] cnt_q;

    assign tick = en && !clr && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/caltime_tod_step.sv
module caltime_tod_step import caltime_pkg::*; (
    input  tod_t cur,
    output tod_t nxt,
    output logic day_carry
);
    always_comb begin
        nxt       = cur;
        day_carry = 1'b0;
        if (cur.second >= 6'd59) begin
            nxt.second = 6'd0;
            if (cur.minute >= 6'd59) begin
                nxt.minute = 6'd0;
                if (cur.hour >= 5'd23) begin
                    nxt.hour  = 5'd0;
                    day_carry = 1'b1;
                end else begin
                    nxt.hour = cur.hour + 5'd1;
                end
            end else begin
                nxt.minute = cur.minute + 6'd1;
            end
        end else begin
            nxt.second = cur.second + 6'd1;
        end
    end
endmodule

// File: rtl/caltime_date_step.sv
module caltime_date_step import caltime_pkg::*; (
    input  date_t      cur,
    input  logic [2:0] dow_in,
    output date_t      nxt,
    output logic [2:0] dow_out,
    output logic [2:0] wom_out
);
    logic [4:0] mlen;

    always_comb begin
        mlen = days_in_month(cur.year, cur.month);
        nxt  = cur;
        if (cur.day >= mlen) begin
            nxt.day = 5'd1;
            if (cur.month >= 4'd12) begin
                nxt.month = 4'd1;
                nxt.year  = cur.year + 12'd1;
            end else begin
                nxt.month = cur.month + 4'd1;
            end
        end else begin
            nxt.day = cur.day + 5'd1;
        end
        dow_out = (dow_in >= 3'd7) ? 3'd1 : dow_in + 3'd1;
        wom_out = week_of_month(nxt.day);
    end
endmodule

// File: rtl/caltime_keeper.sv
module caltime_keeper import caltime_pkg::*; #(
    parameter int unsigned DIV_RELOAD = 32767
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        osc_en,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    output logic [31:0] date_o,
    output logic [31:0] time_o,
    output logic        sec_tick_o,
    output logic        alarm_hit_o
);
    localparam int unsigned DATE_W = $bits(date_t);
    localparam int unsigned TOD_W  = $bits(tod_t);

    step_state_e state_q, state_d;
    date_t       date_q, alm_date_q, date_nxt;
    tod_t        tod_q, alm_tod_q, tod_nxt;
    logic        carry_q, carry_nxt, hit_q, tick, cnt_wr, alm_wr, fields_eq;
    logic [2:0]  dow_nxt, wom_nxt;
    logic        unused_hi_bits;

    assign cnt_wr         = wr_en && !wr_sel[1];
    assign alm_wr         = wr_en &&  wr_sel[1];
    assign unused_hi_bits = ^wr_data[31:TOD_W];

    caltime_prescaler #(.DIV_RELOAD(DIV_RELOAD)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (osc_en),
        .clr  (cnt_wr),
        .tick (tick)
    );

    caltime_tod_step u_tod_step (
        .cur      (tod_q),
        .nxt      (tod_nxt),
        .day_carry(carry_nxt)
    );

    caltime_date_step u_date_step (
        .cur    (date_q),
        .dow_in (tod_q.dow),
        .nxt    (date_nxt),
        .dow_out(dow_nxt),
        .wom_out(wom_nxt)
    );

    assign fields_eq = (date_q == alm_date_q)
                    && (tod_q.hour   == alm_tod_q.hour)
                    && (tod_q.minute == alm_tod_q.minute)
                    && (tod_q.second == alm_tod_q.second);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        if (cnt_wr) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      if (tick) state_d = ST_STEP_TIME;
                ST_STEP_TIME: state_d = ST_STEP_DATE;
                ST_STEP_DATE: state_d = ST_CHECK;
                ST_CHECK:     state_d = ST_IDLE;
            endcase
        end
    end

    // Counter registers and the match pulse, driven per state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            date_q  <= RST_DATE;
            tod_q   <= RST_TOD;
            carry_q <= 1'b0;
            hit_q   <= 1'b0;
        end else if (cnt_wr) begin
            if (wr_sel[0]) tod_q  <= tod_t'(wr_data[TOD_W-1:0]);
            else           date_q <= date_t'(wr_data[DATE_W-1:0]);
            carry_q <= 1'b0;
            hit_q   <= 1'b0;
        end else begin
            hit_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: ;
                ST_STEP_TIME: begin
                    tod_q   <= tod_nxt;
                    carry_q <= carry_nxt;
                end
                ST_STEP_DATE: begin
                    if (carry_q) begin
                        date_q    <= date_nxt;
                        tod_q.dow <= dow_nxt;
                        tod_q.wom <= wom_nxt;
                    end
                end
                ST_CHECK: hit_q <= fields_eq;
            endcase
        end
    end

    // Alarm registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm_date_q <= '0;
            alm_tod_q  <= '0;
        end else if (alm_wr) begin
            if (wr_sel[0]) alm_tod_q  <= tod_t'(wr_data[TOD_W-1:0]);
            else           alm_date_q <= date_t'(wr_data[DATE_W-1:0]);
        end
    end

    assign date_o      = {{(32-DATE_W){1'b0}}, date_q};
    assign time_o      = {{(32-TOD_W){1'b0}}, tod_q};
    assign sec_tick_o  = tick;
    assign alarm_hit_o = hit_q;
endmodule

// File: rtl/caltime_keeper_checker.sv
module caltime_keeper_checker import caltime_pkg::*; (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        wr_hi,
    input logic        sec_tick,
    input logic        hit,
    input logic [16:0] tod_w,
    input logic [20:0] date_w,
    input date_t       alm_date,
    input logic [16:0] alm_tod
);
    // R2: the prescaler never ticks on two consecutive cycles
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);

    // R3: two cycles after an uninterrupted tick the seconds field has stepped
    a_r3_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sec_tick, 2) && !$past(wr_en, 1))
        |-> (tod_w[5:0] == (($past(tod_w[5:0], 2) >= 6'd59) ? 6'd0 : $past(tod_w[5:0], 2) + 6'd1)));

    // R6: the match pulse is one cycle wide
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);

    // R6: while the pulse is high the compared fields equal the alarm
    a_r6_fields_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !$past(wr_en)) |-> ((date_w == alm_date) && (tod_w == alm_tod)));

    // R7: a counter write restarts the prescaler phase
    a_r7_write_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_hi) |=> !sec_tick);
endmodule

bind caltime_keeper caltime_keeper_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_hi   (wr_sel[1]),
    .sec_tick(sec_tick_o),
    .hit     (alarm_hit_o),
    .tod_w   (time_o[16:0]),
    .date_w  (date_o[20:0]),
    .alm_date(alm_date_q),
    .alm_tod (alm_tod_q[16:0])
);

// File: tb/caltime_keeper_tb.sv
module caltime_keeper_tb;
    localparam int DIV     = 5;
    localparam int SEC_CYC = DIV + 1;

    logic        clk = 1'b0, rst_n = 1'b0, osc_en = 1'b0, wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [31:0] date_o, time_o;
    logic        sec_tick_o, alarm_hit_o;

    always #10 clk = ~clk;

    caltime_keeper #(.DIV_RELOAD(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .date_o(date_o), .time_o(time_o),
        .sec_tick_o(sec_tick_o), .alarm_hit_o(alarm_hit_o)
    );

    int n_chk = 0, n_fail = 0, hits = 0, cyc = 0;
    bit done = 1'b0;

    // reference model state
    int pc, age;
    int v_yr, v_mo, v_dy, v_hh, v_mi, v_ss, v_dw, v_wk;
    int n_yr, n_mo, n_dy, n_hh, n_mi, n_ss, n_dw, n_wk;
    int a_yr, a_mo, a_dy, a_hh, a_mi, a_ss;
    bit m_hit;

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_date(int y, int m, int d);
        return 32'((y << 9) | (m << 5) | d);
    endfunction

    function automatic logic [31:0] mk_time(int wk, int dw, int h, int mi, int s);
        return 32'((wk << 20) | (dw << 17) | (h << 12) | (mi << 6) | s);
    endfunction

    function automatic int month_days(int y, int m);
        bit leap;
        leap = (y % 400 == 0) || ((y % 4 == 0) && (y % 100 != 0));
        if (m == 2) return leap ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    // cycle-by-cycle behavioural model
    always @(posedge clk) begin
        bit cw, idle;
        if (!rst_n) begin
            pc = 0; age = 0; m_hit = 0;
            v_yr = 2000; v_mo = 1; v_dy = 1; v_hh = 0; v_mi = 0; v_ss = 0; v_dw = 1; v_wk = 1;
            a_yr = 0; a_mo = 0; a_dy = 0; a_hh = 0; a_mi = 0; a_ss = 0;
        end else begin
            cw    = wr_en && !wr_sel[1];
            idle  = (age == 0);
            m_hit = 0;
            if (cw) begin
                age = 0; pc = 0;
                if (wr_sel[0]) begin
                    v_wk = int'((wr_data >> 20) & 32'h7);  v_dw = int'((wr_data >> 17) & 32'h7);
                    v_hh = int'((wr_data >> 12) & 32'h1f); v_mi = int'((wr_data >> 6) & 32'h3f);
                    v_ss = int'(wr_data & 32'h3f);
                end else begin
                    v_yr = int'((wr_data >> 9) & 32'hfff); v_mo = int'((wr_data >> 5) & 32'hf);
                    v_dy = int'(wr_data & 32'h1f);
                end
            end else begin
                if (age > 0) begin
                    age++;
                    if (age == 2) begin
                        v_ss = n_ss; v_mi = n_mi; v_hh = n_hh;
                    end else if (age == 3) begin
                        v_yr = n_yr; v_mo = n_mo; v_dy = n_dy; v_dw = n_dw; v_wk = n_wk;
                    end else if (age == 4) begin
                        m_hit = (v_yr == a_yr) && (v_mo == a_mo) && (v_dy == a_dy) &&
                                (v_hh == a_hh) && (v_mi == a_mi) && (v_ss == a_ss);
                        age = 0;
                    end
                end
                if (osc_en) begin
                    if (pc == DIV) begin
                        pc = 0;
                        if (idle) begin
                            n_yr = v_yr; n_mo = v_mo; n_dy = v_dy; n_hh = v_hh;
                            n_mi = v_mi; n_ss = v_ss + 1; n_dw = v_dw; n_wk = v_wk;
                            if (n_ss == 60) begin
                                n_ss = 0; n_mi++;
                                if (n_mi == 60) begin
                                    n_mi = 0; n_hh++;
                                    if (n_hh == 24) begin
                                        n_hh = 0;
                                        n_dw = (v_dw == 7) ? 1 : v_dw + 1;
                                        n_dy++;
                                        if (n_dy > month_days(v_yr, v_mo)) begin
                                            n_dy = 1; n_mo++;
                                            if (n_mo == 13) begin n_mo = 1; n_yr++; end
                                        end
                                        n_wk = (n_dy + 6) / 7;
                                    end
                                end
                            end
                            age = 1;
                        end
                    end else begin
                        pc++;
                    end
                end
            end
            if (wr_en && wr_sel[1]) begin
                if (wr_sel[0]) begin
                    a_hh = int'((wr_data >> 12) & 32'h1f); a_mi = int'((wr_data >> 6) & 32'h3f);
                    a_ss = int'(wr_data & 32'h3f);
                end else begin
                    a_yr = int'((wr_data >> 9) & 32'hfff); a_mo = int'((wr_data >> 5) & 32'hf);
                    a_dy = int'(wr_data & 32'h1f);
                end
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        logic [31:0] et, ed;
        bit etick;
        #3;
        if (rst_n && !done) begin
            et    = mk_time(v_wk, v_dw, v_hh, v_mi, v_ss);
            ed    = mk_date(v_yr, v_mo, v_dy);
            etick = osc_en && !(wr_en && !wr_sel[1]) && (pc == DIV);
            check(sec_tick_o == etick, "R2 tick", sec_tick_o, etick);
            check(time_o[16:0] == et[16:0], "R3 hour/min/sec", time_o[16:0], et[16:0]);
            check(time_o[22:17] == et[22:17], "R4 wom/dow", time_o[22:17], et[22:17]);
            check(date_o[20:0] == ed[20:0], "R5 date", date_o[20:0], ed[20:0]);
            check({date_o[31:21], time_o[31:23]} == 20'd0, "R9 upper bits", {date_o[31:21], time_o[31:23]}, 0);
            check(alarm_hit_o == m_hit, "R6 hit", alarm_hit_o, m_hit);
            if (alarm_hit_o) hits++;
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_clock(int y, int m, int d, int dw, int h, int mi, int s);
        wr(2'd0, mk_date(y, m, d));
        wr(2'd1, mk_time((d + 6) / 7, dw, h, mi, s));
    endtask

    task automatic settle(int secs);
        repeat (SEC_CYC * secs + 3) @(negedge clk);
        #3;
    endtask

    task automatic roll(int y, int m, int d, int dw, int ey, int em, int ed, int edw, string tag);
        set_clock(y, m, d, dw, 23, 59, 59);
        settle(1);
        check(date_o == mk_date(ey, em, ed), tag, date_o, mk_date(ey, em, ed));
        check(time_o == mk_time((ed + 6) / 7, edw, 0, 0, 0), "R4 time word after day change",
              time_o, mk_time((ed + 6) / 7, edw, 0, 0, 0));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int first, t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #3;
        check(date_o == mk_date(2000, 1, 1), "R1 reset date", date_o, mk_date(2000, 1, 1));
        check(time_o == mk_time(1, 1, 0, 0, 0), "R1 reset time", time_o, mk_time(1, 1, 0, 0, 0));
        check(alarm_hit_o == 1'b0, "R1 reset hit", alarm_hit_o, 0);
        check(sec_tick_o == 1'b0, "R1 reset tick", sec_tick_o, 0);

        @(negedge clk); osc_en = 1'b1;
        repeat (SEC_CYC * 12) @(negedge clk);

        wr(2'd1, mk_time(3, 4, 12, 34, 56)); #3;
        check(time_o == mk_time(3, 4, 12, 34, 56), "R8 time layout", time_o, mk_time(3, 4, 12, 34, 56));
        wr(2'd0, 32'hFFE0_0000 | mk_date(2024, 2, 28)); #3;
        check(date_o == mk_date(2024, 2, 28), "R9 ignored upper bits", date_o, mk_date(2024, 2, 28));

        // R7: prescaler restarts on a counter write
        wr(2'd1, mk_time(1, 1, 1, 2, 3));
        first = 0;
        for (int c = 1; c <= 20 && first == 0; c++) begin
            if (c > 1) @(negedge clk);
            #3;
            if (sec_tick_o) first = c;
        end
        check(first == SEC_CYC, "R7 first tick after write", first, SEC_CYC);

        // R3 hour carry
        set_clock(2024, 5, 10, 2, 10, 59, 59);
        settle(1);
        check(time_o[16:0] == mk_time(0, 0, 11, 0, 0), "R3 hour carry", time_o[16:0], mk_time(0, 0, 11, 0, 0));

        roll(2023, 12, 31, 7, 2024, 1, 1, 1, "R5 year rollover");
        roll(2024, 2, 28, 3, 2024, 2, 29, 4, "R5 leap February");
        roll(2023, 2, 28, 3, 2023, 3, 1, 4, "R5 common February");
        roll(2100, 2, 28, 1, 2100, 3, 1, 2, "R5 century not leap");
        roll(2000, 2, 28, 1, 2000, 2, 29, 2, "R5 400-year leap");
        roll(2024, 4, 30, 5, 2024, 5, 1, 6, "R5 30-day month");
        roll(2024, 3, 7, 3, 2024, 3, 8, 4, "R4 week of month step");

        // R6: alarm match ignoring weekday/week fields
        wr(2'd2, mk_date(2024, 6, 15));
        wr(2'd3, mk_time(0, 0, 8, 30, 2));
        hits = 0;
        set_clock(2024, 6, 15, 6, 8, 30, 0);
        settle(4);
        check(hits == 1, "R6 one hit on match", hits, 1);

        wr(2'd2, mk_date(2024, 6, 16));
        hits = 0;
        set_clock(2024, 6, 15, 6, 8, 30, 0);
        settle(4);
        check(hits == 0, "R6 no hit on day mismatch", hits, 0);

        // R2: gated oscillator enable
        wr(2'd1, mk_time(1, 1, 0, 0, 0));
        t = 0;
        for (int c = 0; c < 48; c++) begin
            osc_en = (c % 2 == 0);
            #3;
            if (sec_tick_o) t++;
            @(negedge clk);
        end
        osc_en = 1'b1;
        check(t == 4, "R2 ticks with half-rate enable", t, 4);

        // R7: counter write right after a tick cancels the pending step
        set_clock(2024, 7, 1, 1, 12, 0, 0);
        first = 0;
        for (int c = 0; c < 20 && first == 0; c++) begin
            @(negedge clk); #3;
            if (sec_tick_o) first = 1;
        end
        wr(2'd1, mk_time(1, 1, 5, 5, 5));
        repeat (3) @(negedge clk);
        #3;
        check(time_o == mk_time(1, 1, 5, 5, 5), "R7 write cancels step", time_o, mk_time(1, 1, 5, 5, 5));

        repeat (SEC_CYC * 3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule